// File: doc/BRIEF.md
# Four-Block Motion Search Engine

This block estimates motion for four 8x8 blocks of the current frame at once. A host writes the four blocks into a 32x8 current buffer and writes a reference tile, 16 pixels wide and 24 rows tall, into a second buffer. The host then starts a phase. For every position where an 8x8 block fits inside the tile, the engine computes the sum of absolute differences (SAD) for each of the four blocks. Each block keeps the lowest cost found so far and the displacement where that cost occurred.

A full search covers a 40x24 region in four phases. Before phase p the host loads the tile that starts at region column 8p. Each tile therefore shares 8 columns with the tile before it, so a best match that crosses a tile boundary is still found. The engine loads each tile once and compares it against all four blocks. When the last phase ends, the engine raises an interrupt. The host then reads the four results through a block-select port.

The engine uses eight absolute-difference lanes. In each cycle it handles one 8-pixel row of one block at one candidate position. A phase therefore takes a fixed 4896 cycles.

Top module: `mse_engine`

## Requirements
- R1: Current-buffer address bits [7:5] give the row and bits [4:0] give the column. Block b occupies columns 8b to 8b+7. Reference-buffer address bits [8:4] give the row (0..23) and bits [3:0] give the column. Writes to rows 24..31 are dropped.
- R2: The cost of a candidate is the sum of absolute differences over all 64 pixel pairs. An exact match costs 0.
- R3: Within a tile, the horizontal offset runs 0..8 and the vertical offset runs 0..16. The reported horizontal displacement is 8*phase plus the horizontal offset, and the reported vertical displacement is the vertical offset.
- R4: A stored best changes only when a candidate cost is strictly lower. Candidates are scanned in this order: phase ascending, then vertical offset (outer loop), then horizontal offset (inner loop). On a tie the earliest candidate is kept.
- R5: A start with phase 0 sets every stored cost to 16383 and every displacement to (0,0). A start with any other phase keeps the stored values.
- R6: After a start is accepted, busy is high for exactly 4896 cycles. A start pulse that arrives while busy is high is ignored.
- R7: The interrupt is set when phase 3 completes and stays high until irq_clr. Phases 0..2 do not set it.
- R8: Costs are 14 bits wide. The largest SAD, 16320, is reported without wrapping.
- R9: The four blocks are searched independently against the same tile. rd_blk selects which block's result appears on the read outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cur_we | input | 1 | Current-buffer write enable |
| cur_addr | input | 8 | Current-buffer address {row, column} |
| cur_wdata | input | 8 | Current-buffer pixel |
| ref_we | input | 1 | Reference-buffer write enable |
| ref_addr | input | 9 | Reference-buffer address {row, column} |
| ref_wdata | input | 8 | Reference-buffer pixel |
| start | input | 1 | Start-phase pulse |
| start_phase | input | 2 | Number of the phase to run |
| irq_clr | input | 1 | Clears the interrupt |
| rd_blk | input | 2 | Selects the block whose result is read |
| busy | output | 1 | High while a phase runs |
| irq | output | 1 | Search-complete interrupt |
| rd_cost | output | 14 | Best cost of the selected block |
| rd_vx | output | 6 | Best horizontal displacement (0..32) |
| rd_vy | output | 5 | Best vertical displacement (0..16) |

## Verification
The assertions check the following on every cycle:
- a stored cost never rises except on a phase-0 clear;
- stored displacements stay within the region;
- a cost is either at most 16320 or equal to the cleared value;
- the interrupt rises only as a phase ends, and holds until it is cleared;
- busy cannot drop before the final candidate.

Only the bench scenarios can show the remaining behaviour:
- that the winning displacement is correct and that earlier candidates win ties;
- that the phase offset is added to the reported displacement;
- that a non-zero phase keeps earlier results while phase 0 discards them.

// File: rtl/mse_pkg.sv
package mse_pkg;
    localparam int PIX_W    = 8;
    localparam int BLK      = 8;
    localparam int NBLK     = 4;
    localparam int TILE_W   = 16;
    localparam int TILE_H   = 24;
    localparam int NPHASE   = 4;

    localparam int STEP     = TILE_W / 2;
    localparam int CUR_W    = NBLK * BLK;
    localparam int DX_MAX   = TILE_W - BLK;
    localparam int DY_MAX   = TILE_H - BLK;
    localparam int PIX_MAX  = (1 << PIX_W) - 1;
    localparam int COST_CAP = BLK * BLK * PIX_MAX;
    localparam int COST_W   = $clog2(COST_CAP + 1);
    localparam int ROWSUM_W = $clog2(BLK * PIX_MAX + 1);
    localparam int VX_MAX   = STEP * (NPHASE - 1) + DX_MAX;
    localparam int VX_W     = $clog2(VX_MAX + 1);
    localparam int VY_W     = $clog2(DY_MAX + 1);
    localparam int DX_W     = $clog2(DX_MAX + 1);
    localparam int BLK_W    = $clog2(NBLK);
    localparam int ROW_W    = $clog2(BLK);
    localparam int PH_W     = $clog2(NPHASE);
    localparam int CCOL_W   = $clog2(CUR_W);
    localparam int CADDR_W  = ROW_W + CCOL_W;
    localparam int TCOL_W   = $clog2(TILE_W);
    localparam int TROW_W   = $clog2(TILE_H);
    localparam int RADDR_W  = TROW_W + TCOL_W;

    typedef struct packed {
        logic [COST_W-1:0] cost;
        logic [VX_W-1:0]   vx;
        logic [VY_W-1:0]   vy;
    } best_t;
endpackage

// File: rtl/mse_cur_buf.sv
module mse_cur_buf
    import mse_pkg::*;
(
    input  logic                   clk,
    input  logic                   we,
    input  logic [CADDR_W-1:0]     waddr,
    input  logic [PIX_W-1:0]       wdata,
    input  logic [ROW_W-1:0]       rd_row,
    input  logic [BLK_W-1:0]       rd_blk,
    output logic [BLK*PIX_W-1:0]   rd_pix
);
    logic [PIX_W-1:0] mem_q [BLK][CUR_W];
    logic [PIX_W-1:0] mem_d [BLK][CUR_W];

    logic [ROW_W-1:0]  w_row;
    logic [CCOL_W-1:0] w_col;
    assign w_row = waddr[CADDR_W-1:CCOL_W];
    assign w_col = waddr[CCOL_W-1:0];

    always_comb begin
        mem_d = mem_q;
        if (we) mem_d[w_row][w_col] = wdata;
    end

    always_ff @(posedge clk) begin
        mem_q <= mem_d;
    end

    always_comb begin
        for (int k = 0; k < BLK; k++) begin
            rd_pix[k*PIX_W +: PIX_W] = mem_q[rd_row][{rd_blk, ROW_W'(k)}];
        end
    end
endmodule

// File: rtl/mse_ref_buf.sv
module mse_ref_buf
    import mse_pkg::*;
(
    input  logic                   clk,
    input  logic                   we,
    input  logic [RADDR_W-1:0]     waddr,
    input  logic [PIX_W-1:0]       wdata,
    input  logic [TROW_W-1:0]      rd_row,
    input  logic [TCOL_W-1:0]      rd_col,
    output logic [BLK*PIX_W-1:0]   rd_pix
);
    logic [PIX_W-1:0] mem_q [TILE_H][TILE_W];
    logic [PIX_W-1:0] mem_d [TILE_H][TILE_W];

    logic [TROW_W-1:0] w_row;
    logic [TCOL_W-1:0] w_col;
    assign w_row = waddr[RADDR_W-1:TCOL_W];
    assign w_col = waddr[TCOL_W-1:0];

    always_comb begin
        mem_d = mem_q;
        if (we && (int'(w_row) < TILE_H)) mem_d[w_row][w_col] = wdata;
    end

    always_ff @(posedge clk) begin
        mem_q <= mem_d;
    end

    always_comb begin
        for (int k = 0; k < BLK; k++) begin
            rd_pix[k*PIX_W +: PIX_W] = mem_q[rd_row][rd_col + TCOL_W'(k)];
        end
    end
endmodule

// File: rtl/mse_sad_row.sv
module mse_sad_row
    import mse_pkg::*;
#(
    parameter int LANES = BLK
) (
    input  logic [LANES*PIX_W-1:0] a,
    input  logic [LANES*PIX_W-1:0] b,
    output logic [ROWSUM_W-1:0]    sum
);
    logic [PIX_W-1:0] ad [LANES];

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic [PIX_W-1:0] pa, pb;
        assign pa = a[i*PIX_W +: PIX_W];
        assign pb = b[i*PIX_W +: PIX_W];
        assign ad[i] = (pa > pb) ? (pa - pb) : (pb - pa);
    end

    always_comb begin
        sum = '0;
        for (int i = 0; i < LANES; i++) begin
            sum = sum + ROWSUM_W'(ad[i]);
        end
    end
endmodule

// File: rtl/mse_best_bank.sv
module mse_best_bank
    import mse_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              upd,
    input  logic [BLK_W-1:0]  upd_blk,
    input  logic [COST_W-1:0] cand_cost,
    input  logic [VX_W-1:0]   cand_vx,
    input  logic [VY_W-1:0]   cand_vy,
    input  logic [BLK_W-1:0]  rd_blk,
    output best_t             rd_best
);
    localparam best_t EMPTY = '{cost: '1, vx: '0, vy: '0};

    best_t b_q [NBLK];
    best_t b_d [NBLK];

    always_comb begin
        b_d = b_q;
        if (clr) begin
            for (int i = 0; i < NBLK; i++) b_d[i] = EMPTY;
        end else if (upd && (cand_cost < b_q[upd_blk].cost)) begin
            b_d[upd_blk] = '{cost: cand_cost, vx: cand_vx, vy: cand_vy};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NBLK; i++) b_q[i] <= EMPTY;
        end else begin
            b_q <= b_d;
        end
    end

    assign rd_best = b_q[rd_blk];

    for (genvar i = 0; i < NBLK; i++) begin : g_chk
        assert_best_monotone_R4: assert property (@(posedge clk) disable iff (!rst_n)
            !clr |=> (b_q[i].cost <= $past(b_q[i].cost)));
        assert_vec_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (int'(b_q[i].vx) <= VX_MAX) && (int'(b_q[i].vy) <= DY_MAX));
        assert_cost_cap_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (int'(b_q[i].cost) <= COST_CAP) || (b_q[i].cost == '1));
    end
endmodule

// File: rtl/mse_engine.sv
module mse_engine
    import mse_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cur_we,
    input  logic [CADDR_W-1:0] cur_addr,
    input  logic [PIX_W-1:0]   cur_wdata,
    input  logic               ref_we,
    input  logic [RADDR_W-1:0] ref_addr,
    input  logic [PIX_W-1:0]   ref_wdata,
    input  logic               start,
    input  logic [PH_W-1:0]    start_phase,
    input  logic               irq_clr,
    input  logic [BLK_W-1:0]   rd_blk,
    output logic               busy,
    output logic               irq,
    output logic [COST_W-1:0]  rd_cost,
    output logic [VX_W-1:0]    rd_vx,
    output logic [VY_W-1:0]    rd_vy
);
    typedef enum logic {S_IDLE, S_RUN} st_e;

    typedef struct packed {
        st_e               st;
        logic [PH_W-1:0]   phase;
        logic [VY_W-1:0]   dy;
        logic [DX_W-1:0]   dx;
        logic [BLK_W-1:0]  blk;
        logic [ROW_W-1:0]  row;
        logic [COST_W-1:0] acc;
        logic              irq;
    } ctl_t;

    localparam logic [ROW_W-1:0] ROW_LAST = ROW_W'(BLK - 1);
    localparam logic [BLK_W-1:0] BLK_LAST = BLK_W'(NBLK - 1);
    localparam logic [DX_W-1:0]  DX_LAST  = DX_W'(DX_MAX);
    localparam logic [VY_W-1:0]  DY_LAST  = VY_W'(DY_MAX);
    localparam logic [PH_W-1:0]  PH_LAST  = PH_W'(NPHASE - 1);

    ctl_t c_q, c_d;

    logic [BLK*PIX_W-1:0] cur_pix, ref_pix;
    logic [ROWSUM_W-1:0]  rowsum;
    logic [COST_W-1:0]    cost_now;
    logic [VX_W-1:0]      cand_vx;
    logic                 clr, upd, last_step;
    best_t                rd_best;

    mse_cur_buf u_cur (
        .clk    (clk),
        .we     (cur_we),
        .waddr  (cur_addr),
        .wdata  (cur_wdata),
        .rd_row (c_q.row),
        .rd_blk (c_q.blk),
        .rd_pix (cur_pix)
    );

    mse_ref_buf u_ref (
        .clk    (clk),
        .we     (ref_we),
        .waddr  (ref_addr),
        .wdata  (ref_wdata),
        .rd_row (TROW_W'(c_q.dy) + TROW_W'(c_q.row)),
        .rd_col (TCOL_W'(c_q.dx)),
        .rd_pix (ref_pix)
    );

    mse_sad_row #(.LANES(BLK)) u_sad (
        .a   (cur_pix),
        .b   (ref_pix),
        .sum (rowsum)
    );

    assign cost_now  = c_q.acc + COST_W'(rowsum);
    assign cand_vx   = VX_W'(c_q.phase) * VX_W'(STEP) + VX_W'(c_q.dx);
    assign last_step = (c_q.row == ROW_LAST) && (c_q.blk == BLK_LAST) &&
                       (c_q.dx == DX_LAST) && (c_q.dy == DY_LAST);

    always_comb begin
        c_d = c_q;
        clr = 1'b0;
        upd = 1'b0;
        if (irq_clr) c_d.irq = 1'b0;
        case (c_q.st)
            S_IDLE: begin
                if (start) begin
                    c_d.st    = S_RUN;
                    c_d.phase = start_phase;
                    c_d.dy    = '0;
                    c_d.dx    = '0;
                    c_d.blk   = '0;
                    c_d.row   = '0;
                    c_d.acc   = '0;
                    clr       = (start_phase == '0);
                end
            end
            S_RUN: begin
                if (c_q.row == ROW_LAST) begin
                    upd     = 1'b1;
                    c_d.acc = '0;
                    c_d.row = '0;
                    if (c_q.blk == BLK_LAST) begin
                        c_d.blk = '0;
                        if (c_q.dx == DX_LAST) begin
                            c_d.dx = '0;
                            if (c_q.dy == DY_LAST) begin
                                c_d.dy = '0;
                                c_d.st = S_IDLE;
                                if (c_q.phase == PH_LAST) c_d.irq = 1'b1;
                            end else begin
                                c_d.dy = c_q.dy + VY_W'(1);
                            end
                        end else begin
                            c_d.dx = c_q.dx + DX_W'(1);
                        end
                    end else begin
                        c_d.blk = c_q.blk + BLK_W'(1);
                    end
                end else begin
                    c_d.row = c_q.row + ROW_W'(1);
                    c_d.acc = cost_now;
                end
            end
            default: c_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q <= '{st: S_IDLE, default: '0};
        end else begin
            c_q <= c_d;
        end
    end

    mse_best_bank u_best (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (clr),
        .upd       (upd),
        .upd_blk   (c_q.blk),
        .cand_cost (cost_now),
        .cand_vx   (cand_vx),
        .cand_vy   (c_q.dy),
        .rd_blk    (rd_blk),
        .rd_best   (rd_best)
    );

    assign busy    = (c_q.st == S_RUN);
    assign irq     = c_q.irq;
    assign rd_cost = rd_best.cost;
    assign rd_vx   = rd_best.vx;
    assign rd_vy   = rd_best.vy;

    assert_irq_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !irq_clr) |=> irq);
    assert_irq_source_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(busy));
    assert_run_length_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !last_step) |=> busy);
    assert_clear_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        clr |-> !busy);
endmodule

// File: tb/mse_engine_tb.sv
module mse_engine_tb;
    import mse_pkg::*;

    localparam int RW = STEP * (NPHASE - 1) + TILE_W;
    localparam int PHASE_CYC = (DY_MAX + 1) * (DX_MAX + 1) * NBLK * BLK;

    typedef struct {
        int    cost;
        int    vx;
        int    vy;
        string tag;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cur_we = 1'b0, ref_we = 1'b0, start = 1'b0, irq_clr = 1'b0;
    logic [CADDR_W-1:0] cur_addr = '0;
    logic [RADDR_W-1:0] ref_addr = '0;
    logic [PIX_W-1:0]   cur_wdata = '0, ref_wdata = '0;
    logic [PH_W-1:0]    start_phase = '0;
    logic [BLK_W-1:0]   rd_blk = '0;
    logic busy, irq;
    logic [COST_W-1:0] rd_cost;
    logic [VX_W-1:0]   rd_vx;
    logic [VY_W-1:0]   rd_vy;

    int checks = 0, errors = 0, cycles = 0;
    int cur_img [BLK][CUR_W];
    int ref_img [TILE_H][RW];
    int m_cost [NBLK];
    int m_vx [NBLK];
    int m_vy [NBLK];
    exp_t sb [$];

    always #2.5 clk = ~clk;

    mse_engine u_dut (
        .clk(clk), .rst_n(rst_n), .cur_we(cur_we), .cur_addr(cur_addr), .cur_wdata(cur_wdata),
        .ref_we(ref_we), .ref_addr(ref_addr), .ref_wdata(ref_wdata), .start(start),
        .start_phase(start_phase), .irq_clr(irq_clr), .rd_blk(rd_blk), .busy(busy), .irq(irq),
        .rd_cost(rd_cost), .rd_vx(rd_vx), .rd_vy(rd_vy)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Monitor: pops expected per-block results when a phase ends
    initial begin
        forever begin
            @(negedge busy);
            for (int b = 0; b < NBLK; b++) begin
                exp_t e;
                if (sb.size() == 0) begin
                    check(1'b0, "scoreboard empty", 0, 1);
                end else begin
                    e = sb.pop_front();
                    rd_blk = BLK_W'(b);
                    #1;
                    check(int'(rd_cost) == e.cost, {e.tag, " cost"}, int'(rd_cost), e.cost);
                    check(int'(rd_vx) == e.vx, {e.tag, " vx"}, int'(rd_vx), e.vx);
                    check(int'(rd_vy) == e.vy, {e.tag, " vy"}, int'(rd_vy), e.vy);
                end
            end
        end
    end

    task automatic load_cur();
        for (int r = 0; r < BLK; r++) begin
            for (int c = 0; c < CUR_W; c++) begin
                @(negedge clk);
                cur_we = 1'b1;
                cur_addr = {ROW_W'(r), CCOL_W'(c)};   // R1 layout
                cur_wdata = PIX_W'(cur_img[r][c]);
            end
        end
        @(negedge clk);
        cur_we = 1'b0;
    endtask

    task automatic load_tile(input int p);
        for (int r = 0; r < TILE_H; r++) begin
            for (int c = 0; c < TILE_W; c++) begin
                @(negedge clk);
                ref_we = 1'b1;
                ref_addr = {TROW_W'(r), TCOL_W'(c)};
                ref_wdata = PIX_W'(ref_img[r][STEP*p + c]);
            end
        end
        @(negedge clk);
        ref_we = 1'b0;
    endtask

    // Reference model for one phase (R2, R3, R4, R5)
    task automatic model_phase(input int p, input string tag);
        if (p == 0) begin
            for (int b = 0; b < NBLK; b++) begin
                m_cost[b] = (1 << COST_W) - 1; m_vx[b] = 0; m_vy[b] = 0;
            end
        end
        for (int dy = 0; dy <= DY_MAX; dy++) begin
            for (int dx = 0; dx <= DX_MAX; dx++) begin
                for (int b = 0; b < NBLK; b++) begin
                    int s = 0;
                    for (int r = 0; r < BLK; r++) begin
                        for (int c = 0; c < BLK; c++) begin
                            int d = cur_img[r][BLK*b + c] - ref_img[dy + r][STEP*p + dx + c];
                            s += (d < 0) ? -d : d;
                        end
                    end
                    if (s < m_cost[b]) begin
                        m_cost[b] = s; m_vx[b] = STEP*p + dx; m_vy[b] = dy;
                    end
                end
            end
        end
        for (int b = 0; b < NBLK; b++) begin
            exp_t e;
            e.cost = m_cost[b]; e.vx = m_vx[b]; e.vy = m_vy[b];
            e.tag = $sformatf("%s blk%0d ph%0d", tag, b, p);
            sb.push_back(e);
        end
    endtask

    task automatic run_phase(input int p, input string tag, input bit inject);
        int n = 0;
        load_tile(p);
        model_phase(p, tag);
        @(negedge clk);
        start = 1'b1; start_phase = PH_W'(p);
        @(negedge clk);
        start = 1'b0;
        while (busy && n < PHASE_CYC + 10) begin
            n++;
            if (inject && n == 100) begin
                start = 1'b1; start_phase = '0;     // R6: ignored while busy
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
        end
        start = 1'b0;
        check(n == PHASE_CYC, "R6 busy length", n, PHASE_CYC);
        check(irq == (p == NPHASE - 1), "R7 irq after phase", int'(irq), int'(p == NPHASE - 1));
        repeat (4) @(negedge clk);
    endtask

    task automatic clear_irq();
        repeat (5) @(negedge clk);
        check(irq == 1'b1, "R7 irq held", int'(irq), 1);
        irq_clr = 1'b1;
        @(negedge clk);
        irq_clr = 1'b0;
        check(irq == 1'b0, "R7 irq cleared", int'(irq), 0);
    endtask

    task automatic full_search(input string tag, input bit inject);
        load_cur();
        for (int p = 0; p < NPHASE; p++) run_phase(p, tag, inject && p == 2);
        clear_irq();
    endtask

    // Watchdog
    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 190000) begin
                checks++; errors++;
                $display("FAIL watchdog actual=%0d expected<=%0d", cycles, 190000);
                $display("Simulation finished: %0d checks, %0d errors", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        int bx [NBLK] = '{3, 8, 21, 32};
        int by [NBLK] = '{5, 0, 16, 9};
        repeat (3) @(negedge clk);
        check(busy == 1'b0, "reset busy", int'(busy), 0);
        check(irq == 1'b0, "reset irq", int'(irq), 0);
        check(int'(rd_cost) == (1 << COST_W) - 1, "R5 reset cost", int'(rd_cost), (1 << COST_W) - 1);
        rst_n = 1'b1;
        @(negedge clk);

        // Scenario A: textured region, exact copies embedded (R1 R2 R3 R9), start injected (R6)
        for (int y = 0; y < TILE_H; y++)
            for (int x = 0; x < RW; x++)
                ref_img[y][x] = ((x * 37 + y * 11 + 5) ^ (x * y * 3)) & 255;
        for (int b = 0; b < NBLK; b++)
            for (int r = 0; r < BLK; r++)
                for (int c = 0; c < BLK; c++)
                    cur_img[r][BLK*b + c] = ref_img[by[b] + r][bx[b] + c];
        full_search("R1/R2/R3/R9 exact", 1'b1);
        for (int b = 0; b < NBLK; b++)
            check(m_vx[b] == bx[b] && m_cost[b] == 0, "R2 model sanity", m_vx[b], bx[b]);

        // Scenario B: flat images, every candidate ties (R4)
        for (int y = 0; y < TILE_H; y++) for (int x = 0; x < RW; x++) ref_img[y][x] = 7;
        for (int r = 0; r < BLK; r++) for (int c = 0; c < CUR_W; c++) cur_img[r][c] = 7;
        full_search("R4 tie", 1'b0);

        // Scenario C: largest cost (R8)
        for (int y = 0; y < TILE_H; y++) for (int x = 0; x < RW; x++) ref_img[y][x] = 0;
        for (int r = 0; r < BLK; r++) for (int c = 0; c < CUR_W; c++) cur_img[r][c] = 255;
        full_search("R8 max", 1'b0);

        // Scenario D: phase 0 clears, phase 1 keeps (R5)
        for (int y = 0; y < TILE_H; y++) for (int x = 0; x < RW; x++) ref_img[y][x] = 100;
        for (int r = 0; r < BLK; r++)
            for (int c = 0; c < CUR_W; c++) cur_img[r][c] = (r * 13 + c * 7) & 255;
        load_cur();
        run_phase(0, "R5 clear", 1'b0);
        run_phase(1, "R5 keep", 1'b0);

        repeat (5) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule